// File: doc/BRIEF.md
# Add/Subtract and Logic ALU With Status Flags

This block is a purely combinational arithmetic logic unit for an N-bit datapath (N = 16 by default). A 2-bit function code selects one of four operations on two operands: an arithmetic operation, the inverse of the second operand, a bitwise OR, or a bitwise AND. A separate control bit chooses between addition and subtraction for the arithmetic operation. Both directions run through one ripple-carry chain of full adders. To subtract, the second operand is inverted and the carry into the lowest stage is set.

Beside the result word, the block reports four status bits. These are the carry out of the top adder stage, an unsigned overflow bit, a signed overflow bit and a bit that is high when any result bit is set. The three arithmetic status bits are meaningful only for the arithmetic function, and they read zero for the other three. There is no clock and no storage, so every output follows the inputs after the logic settles.

Top module: `addlog_alu`

## Requirements
- R1: With fn_sel = 0 and sub_en = 0, result equals (op_a + op_b) modulo 2^N.
- R2: With fn_sel = 0 and sub_en = 1, result equals (op_a - op_b) modulo 2^N, formed as op_a + ~op_b + 1.
- R3: With fn_sel = 1, result equals ~op_b, and sub_en has no effect on any output.
- R4: With fn_sel = 2, result equals op_a | op_b.
- R5: With fn_sel = 3, result equals op_a & op_b.
- R6: With fn_sel = 0, carry_out is the carry leaving the most significant adder stage. For addition it is bit N of op_a + op_b. For subtraction it is 1 exactly when op_a >= op_b as unsigned numbers.
- R7: With fn_sel = 0, ovf_unsigned is derived from that carry. It is 1 for addition when carry_out is 1, and for subtraction when carry_out is 0 (a borrow, op_a < op_b unsigned).
- R8: With fn_sel = 0, ovf_signed is the XOR of the carry into and the carry out of the most significant stage. It is 1 exactly when the two's-complement result is out of range.
- R9: When fn_sel is not 0, carry_out, ovf_unsigned and ovf_signed are all 0.
- R10: nonzero is 1 exactly when at least one bit of result is 1, for every function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| fn_sel | input | 2 | Function code: 0 arithmetic, 1 invert op_b, 2 OR, 3 AND |
| sub_en | input | 1 | For fn_sel 0: 0 adds, 1 subtracts |
| result | output | N | Selected result word |
| carry_out | output | 1 | Carry out of the top adder stage (fn_sel 0 only) |
| ovf_unsigned | output | 1 | Unsigned overflow or borrow (fn_sel 0 only) |
| ovf_signed | output | 1 | Two's-complement overflow (fn_sel 0 only) |
| nonzero | output | 1 | High when any result bit is set |

## Verification
The bench targets the signed boundaries: the most positive value plus one, the most negative value minus one, and zero minus zero. A design with the wrong carry-in polarity or a mistaken overflow XOR either reports overflow on zero minus zero or misses the wrap at the extremes. It also checks subtraction with equal operands and with op_a below op_b. Tying the unsigned flag directly to the raw carry would show up there as an inverted borrow. A ripple chain that drops a carry between stages gives a wrong sum for all-ones plus one. Flags that leak from the adder into the logic functions are caught by driving operands that overflow while fn_sel is 1, 2 or 3, and sub_en is toggled under fn_sel 1 to show it is ignored.

// File: rtl/addlog_alu_pkg.sv
package addlog_alu_pkg;

    typedef enum logic [1:0] {
        FN_ARITH = 2'd0,
        FN_INVB  = 2'd1,
        FN_OR    = 2'd2,
        FN_AND   = 2'd3
    } alu_fn_e;

    typedef struct packed {
        logic carry;
        logic ovf_u;
        logic ovf_s;
    } arith_flags_t;

    function automatic logic fa_sum(input logic x, input logic y, input logic ci);
        return x ^ y ^ ci;
    endfunction

    function automatic logic fa_carry(input logic x, input logic y, input logic ci);
        return (x & y) | (x & ci) | (y & ci);
    endfunction

endpackage

// File: rtl/addlog_ripple_adder.sv
module addlog_ripple_adder
    import addlog_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         cin_msb
);
    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_stage
        assign sum[i]     = fa_sum(x[i], y[i], chain[i]);
        assign chain[i+1] = fa_carry(x[i], y[i], chain[i]);
    end

    assign cout    = chain[W];
    assign cin_msb = chain[W-1];

    // R1 R2: the ripple chain matches a full-width sum
    always_comb begin
        if (!$isunknown({x, y, cin})) begin
            p_ripple_sum_r1: assert ({cout, sum} == ({1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin}))
                else $error("ripple chain sum mismatch");
        end
    end

endmodule

// File: rtl/addlog_bitwise.sv
module addlog_bitwise
    import addlog_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  alu_fn_e      fn,
    output logic [W-1:0] out
);
    always_comb begin
        unique case (fn)
            FN_INVB: out = ~y;
            FN_OR:   out = x | y;
            FN_AND:  out = x & y;
            default: out = '0;
        endcase
    end
endmodule

// File: rtl/addlog_flag_gen.sv
module addlog_flag_gen
    import addlog_alu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         is_arith,
    input  logic         sub,
    input  logic         cout,
    input  logic         cin_msb,
    input  logic [W-1:0] res,
    output arith_flags_t flags,
    output logic         any_set
);
    always_comb begin
        flags = '0;
        if (is_arith) begin
            flags.carry = cout;
            flags.ovf_u = cout ^ sub;
            flags.ovf_s = cout ^ cin_msb;
        end
    end

    assign any_set = |res;
endmodule

// File: rtl/addlog_alu.sv
module addlog_alu
    import addlog_alu_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0] op_a,
    input  logic [N-1:0] op_b,
    input  logic [1:0]   fn_sel,
    input  logic         sub_en,
    output logic [N-1:0] result,
    output logic         carry_out,
    output logic         ovf_unsigned,
    output logic         ovf_signed,
    output logic         nonzero
);
    localparam int MSB = N - 1;

    alu_fn_e      fn;
    logic [N-1:0] b_eff;
    logic [N-1:0] add_sum;
    logic         add_cout;
    logic         add_cmsb;
    logic [N-1:0] logic_out;
    logic         is_arith;
    arith_flags_t flags;

    assign fn       = alu_fn_e'(fn_sel);
    assign is_arith = (fn == FN_ARITH);
    assign b_eff    = op_b ^ {N{sub_en}};

    addlog_ripple_adder #(.W(N)) u_adder (
        .x       (op_a),
        .y       (b_eff),
        .cin     (sub_en),
        .sum     (add_sum),
        .cout    (add_cout),
        .cin_msb (add_cmsb)
    );

    addlog_bitwise #(.W(N)) u_logic (
        .x   (op_a),
        .y   (op_b),
        .fn  (fn),
        .out (logic_out)
    );

    assign result = is_arith ? add_sum : logic_out;

    addlog_flag_gen #(.W(N)) u_flags (
        .is_arith (is_arith),
        .sub      (sub_en),
        .cout     (add_cout),
        .cin_msb  (add_cmsb),
        .res      (result),
        .flags    (flags),
        .any_set  (nonzero)
    );

    assign carry_out    = flags.carry;
    assign ovf_unsigned = flags.ovf_u;
    assign ovf_signed   = flags.ovf_s;

    always_comb begin
        if (!$isunknown({op_a, op_b, fn_sel, sub_en})) begin
            // R9: arithmetic flags quiet outside the arithmetic function
            p_no_flags_r9: assert (is_arith || !(carry_out || ovf_unsigned || ovf_signed))
                else $error("flags set outside arithmetic");
            // R3: invert function returns ~op_b
            p_invb_r3: assert (fn != FN_INVB || result == ~op_b)
                else $error("invert result wrong");
            // R10: nonzero agrees with the result word
            p_nonzero_r10: assert (nonzero == (result != '0))
                else $error("nonzero flag wrong");
            // R8: signed overflow only when operand signs agree and result sign differs
            p_sovf_r8: assert (!ovf_signed ||
                               (op_a[MSB] == b_eff[MSB] && result[MSB] != op_a[MSB]))
                else $error("signed overflow inconsistent");
        end
    end

endmodule

// File: tb/addlog_alu_bench.sv
module addlog_alu_bench;
    localparam int N = 16;
    localparam int NV = 18;
    localparam logic [N-1:0] MAXP = {1'b0, {(N-1){1'b1}}};
    localparam logic [N-1:0] MAXN = {1'b1, {(N-1){1'b0}}};
    localparam logic [N-1:0] ONES = '1;

    // each entry: {op_a, op_b, fn_sel, sub_en}
    localparam logic [2*N+2:0] VEC [NV] = '{
        {16'h0003, 16'h0004, 2'd0, 1'b0},
        {MAXP,     16'h0001, 2'd0, 1'b0},
        {ONES,     16'h0001, 2'd0, 1'b0},
        {MAXN,     MAXN,     2'd0, 1'b0},
        {16'h1234, 16'h4321, 2'd0, 1'b0},
        {MAXN,     16'h0001, 2'd0, 1'b1},
        {16'h0000, 16'h0000, 2'd0, 1'b1},
        {16'h0005, 16'h0005, 2'd0, 1'b1},
        {16'h0002, 16'h0007, 2'd0, 1'b1},
        {16'h8000, 16'h7FFF, 2'd0, 1'b1},
        {16'h0000, 16'h00FF, 2'd1, 1'b0},
        {16'hFFFF, 16'h00FF, 2'd1, 1'b1},
        {16'h1234, ONES,     2'd1, 1'b0},
        {16'hF0F0, 16'h0F0F, 2'd2, 1'b0},
        {16'h0000, 16'h0000, 2'd2, 1'b1},
        {ONES,     ONES,     2'd2, 1'b0},
        {16'hF0F0, 16'h0F0F, 2'd3, 1'b0},
        {ONES,     16'hA5A5, 2'd3, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] op_a, op_b, result;
    logic [1:0] fn_sel;
    logic sub_en, carry_out, ovf_unsigned, ovf_signed, nonzero;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    addlog_alu #(.N(N)) u_addlog_alu (
        .op_a(op_a), .op_b(op_b), .fn_sel(fn_sel), .sub_en(sub_en),
        .result(result), .carry_out(carry_out), .ovf_unsigned(ovf_unsigned),
        .ovf_signed(ovf_signed), .nonzero(nonzero)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h (a=%h b=%h fn=%0d sub=%0b)",
                     req, act, exp, op_a, op_b, fn_sel, sub_en);
        end
    endtask

    task automatic apply(input logic [N-1:0] a, input logic [N-1:0] b,
                         input logic [1:0] f, input logic s);
        logic [N:0] wide;
        logic [N-1:0] er;
        logic ec, eu, es;
        string rtag;
        @(negedge clk);
        op_a = a; op_b = b; fn_sel = f; sub_en = s;
        #2;
        ec = 1'b0; eu = 1'b0; es = 1'b0;
        case (f)
            2'd0: begin
                if (!s) begin
                    wide = {1'b0, a} + {1'b0, b};
                    er = wide[N-1:0];
                    ec = wide[N];
                    eu = wide[N];
                    es = (a[N-1] == b[N-1]) && (er[N-1] != a[N-1]);
                    rtag = "R1";
                end else begin
                    er = a - b;
                    ec = (a >= b);
                    eu = (a < b);
                    es = (a[N-1] != b[N-1]) && (er[N-1] != a[N-1]);
                    rtag = "R2";
                end
            end
            2'd1: begin er = ~b; rtag = "R3"; end
            2'd2: begin er = a | b; rtag = "R4"; end
            default: begin er = a & b; rtag = "R5"; end
        endcase
        chk(rtag, result, er);
        if (f == 2'd0) begin
            chk("R6", {15'd0, carry_out}, {15'd0, ec});
            chk("R7", {15'd0, ovf_unsigned}, {15'd0, eu});
            chk("R8", {15'd0, ovf_signed}, {15'd0, es});
        end else begin
            chk("R9", {13'd0, carry_out, ovf_unsigned, ovf_signed}, 16'd0);
        end
        chk("R10", {15'd0, nonzero}, {15'd0, (er != '0)});
    endtask

    initial begin : watchdog
        int cyc;
        for (cyc = 0; cyc < 20000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        op_a = '0; op_b = '0; fn_sel = 2'd0; sub_en = 1'b0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // quiescent state with all-zero inputs: R1 sum 0, R10 nonzero low
        #2;
        chk("R1", result, 16'd0);
        chk("R10", {15'd0, nonzero}, 16'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][2*N+2:N+3], VEC[i][N+2:3], VEC[i][2:1], VEC[i][0]);
        end

        // directed signed corners
        apply(MAXP, 16'h0001, 2'd0, 1'b0);   // R8 most positive plus one
        apply(MAXN, 16'h0001, 2'd0, 1'b1);   // R8 most negative minus one
        apply(16'h0000, 16'h0000, 2'd0, 1'b1); // R2 R6 R7 zero minus zero
        apply(MAXN, MAXP, 2'd0, 1'b0);       // R1 -1 result, no overflow
        // R3: sub_en ignored under invert, compare both settings
        apply(16'hAAAA, 16'h1357, 2'd1, 1'b0);
        apply(16'hAAAA, 16'h1357, 2'd1, 1'b1);
        // R9: operands that would overflow under logic functions
        apply(MAXP, 16'h0001, 2'd2, 1'b0);
        apply(ONES, ONES, 2'd3, 1'b1);
        apply(MAXN, 16'h0001, 2'd1, 1'b1);
        // R10 with a single high bit
        apply(16'h8000, 16'h0000, 2'd2, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule